// File: doc/BRIEF.md
# LIN frame response controller

This block handles a LIN frame at byte level, on behalf of either a master or a slave node. An external UART shifter produces the break and sync fields. This engine takes over at the identifier byte. On transmit it builds the protected identifier, with the two parity bits inserted. On receive it checks the parity and stores the identifier. The parity can be switched off for a frame.

Once the header has passed, the node acts in one of three ways for that frame:
- It publishes the response: data bytes come in from a local source and go out through the shifter, followed by a checksum byte.
- It subscribes to the response: it captures the bus bytes and checks the checksum.
- It ignores the response: it counts the bytes only, so that it stays aligned with the frame.

The number of data bytes comes from one of two places: an 8-bit length field that encodes 1 to 256 bytes, or identifier bits 5:4.

Software writes the frame configuration and then pulses `start_i`. The configuration is captured at that moment. Every byte towards the shifter uses a valid/ready handshake. At the end of the frame `done_o` pulses for one cycle, and the two error flags stay valid until the next start.

Top module: `lin_resp_ctrl`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `tx_valid_o`, `rx_ready_o`, `pub_ready_o`, `sub_valid_o`, `pid_err_o` and `cks_err_o` are all 0.
- R2: When the header is transmitted with parity enabled, the byte sent is the identifier bits 5:0 with bit 6 = id0^id1^id2^id4 and bit 7 = ~(id1^id3^id4^id5).
- R3: With parity disabled, the transmitted header byte equals all 8 configured bits, and a received header is stored in `pid_o` unchanged with `pid_err_o` low.
- R4: When the header is received with parity enabled, `pid_o` shows bits 7:6 as 0, and `pid_err_o` rises if either received parity bit differs from the R2 formula.
- R5: In user length mode (`cfg_len_mode_i`=0), the response carries `cfg_len_i`+1 data bytes (1 to 256) before the checksum.
- R6: In identifier length mode (`cfg_len_mode_i`=1), identifier bits 5:4 select the data byte count: 00 or 01 gives 2, 10 gives 4, 11 gives 8.
- R7: In publish mode (`cfg_act_i`=01), the data bytes accepted on the publish port are sent in order. They are followed by one checksum byte, which is the inverse of their 8-bit sum with each carry added back in.
- R8: In subscribe mode (`cfg_act_i`=10), each received data byte appears on `sub_data_o`, with a one-cycle `sub_valid_o`, in the cycle after it is accepted. `cks_err_o` rises when the received checksum byte differs from the R7 value.
- R9: In ignore mode (`cfg_act_i`=00, and also 11), the block accepts the data bytes and the checksum byte from the bus, but never raises `sub_valid_o` or `cks_err_o`.
- R10: `done_o` pulses for exactly one cycle, in the cycle after the checksum byte is exchanged. `busy_o` is then low.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value.
- R12: The configuration inputs are sampled only on `start_i` in the idle state. Changes made while a frame is in progress do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame at the identifier field |
| hdr_tx_i | input | 1 | 1: this node sends the identifier; 0: it receives it |
| cfg_par_off_i | input | 1 | 1: identifier parity disabled |
| cfg_act_i | input | 2 | Response action: 00 ignore, 01 publish, 10 subscribe, 11 ignore |
| cfg_len_mode_i | input | 1 | 0: length from cfg_len_i; 1: length from identifier bits 5:4 |
| cfg_len_i | input | 8 | Data byte count minus one |
| cfg_id_i | input | 8 | Identifier to transmit |
| tx_data_o | output | 8 | Byte to the shifter |
| tx_valid_o | output | 1 | tx_data_o is valid |
| tx_ready_i | input | 1 | Shifter accepts the byte |
| rx_data_i | input | 8 | Byte from the shifter |
| rx_valid_i | input | 1 | rx_data_i is valid |
| rx_ready_o | output | 1 | Engine accepts a received byte |
| pub_data_i | input | 8 | Local response data to publish |
| pub_valid_i | input | 1 | pub_data_i is valid |
| pub_ready_o | output | 1 | Publish byte consumed |
| sub_data_o | output | 8 | Captured response data byte |
| sub_valid_o | output | 1 | One-cycle strobe for sub_data_o |
| pid_o | output | 8 | Identifier of the current frame as stored or sent |
| pid_err_o | output | 1 | Identifier parity error, held until the next start |
| cks_err_o | output | 1 | Checksum mismatch, held until the next start |
| done_o | output | 1 | Frame complete strobe |
| busy_o | output | 1 | Frame in progress |

## Verification
The hold check on the transmit side relies on the local data source. Once `pub_valid_i` is high, that source must keep it high and keep `pub_data_i` steady until `pub_ready_o` takes the byte. The bench raises its publish data before each byte and changes it only after the handshake cycle. The bench also stalls `tx_ready_i` for several cycles to test that hold.

The count bound assumes the frame runs only through the sequence the engine controls. `rx_valid_i` may toggle freely, because it is only consumed while `rx_ready_o` is high. The bench therefore drives each received byte until it sees ready, and then drops valid.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;
  typedef enum logic [1:0] {
    ACT_IGNORE    = 2'b00,
    ACT_PUBLISH   = 2'b01,
    ACT_SUBSCRIBE = 2'b10,
    ACT_RSVD      = 2'b11
  } node_act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_TX,
    ST_HDR_RX,
    ST_DATA,
    ST_CKS
  } fsm_e;
endpackage

// File: rtl/lin_pid_unit.sv
module lin_pid_unit (
  input  logic [7:0] id_i,
  input  logic [7:0] rx_byte_i,
  input  logic       par_off_i,
  output logic [7:0] tx_byte_o,
  output logic [7:0] rx_store_o,
  output logic       par_err_o
);
  logic [1:0] tx_par, rx_par;

  always_comb begin
    tx_par[0] = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
    tx_par[1] = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
    rx_par[0] = rx_byte_i[0] ^ rx_byte_i[1] ^ rx_byte_i[2] ^ rx_byte_i[4];
    rx_par[1] = ~(rx_byte_i[1] ^ rx_byte_i[3] ^ rx_byte_i[4] ^ rx_byte_i[5]);
    tx_byte_o  = par_off_i ? id_i : {tx_par, id_i[5:0]};
    rx_store_o = par_off_i ? rx_byte_i : {2'b00, rx_byte_i[5:0]};
    par_err_o  = !par_off_i && (rx_par != rx_byte_i[7:6]);
  end
endmodule

// File: rtl/lin_len_sel.sv
module lin_len_sel #(
  parameter int LEN_W = 8
) (
  input  logic             id_mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       id_bits_i,
  output logic [LEN_W-1:0] last_idx_o
);
  logic [LEN_W-1:0] id_last;

  always_comb begin
    unique case (id_bits_i)
      2'b10:   id_last = LEN_W'(3);
      2'b11:   id_last = LEN_W'(7);
      default: id_last = LEN_W'(1);
    endcase
    last_idx_o = id_mode_i ? id_last : len_i;
  end
endmodule

// File: rtl/lin_cksum_acc.sv
module lin_cksum_acc #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] cks_o
);
  logic [DW-1:0] sum_q;
  logic [DW:0]   raw;
  logic [DW-1:0] wrapped;

  always_comb begin
    raw     = {1'b0, sum_q} + {1'b0, byte_i};
    wrapped = raw[DW-1:0] + DW'(raw[DW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= wrapped;
  end

  assign cks_o = ~sum_q;
endmodule

// File: rtl/lin_resp_ctrl.sv
module lin_resp_ctrl
  import lin_resp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hdr_tx_i,
  input  logic             cfg_par_off_i,
  input  logic [1:0]       cfg_act_i,
  input  logic             cfg_len_mode_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [7:0]       cfg_id_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [7:0]       pub_data_i,
  input  logic             pub_valid_i,
  output logic             pub_ready_o,
  output logic [7:0]       sub_data_o,
  output logic             sub_valid_o,
  output logic [7:0]       pid_o,
  output logic             pid_err_o,
  output logic             cks_err_o,
  output logic             done_o,
  output logic             busy_o
);
  fsm_e             state_q;
  node_act_e        act_q;
  logic             hdr_tx_q, par_off_q, len_mode_q;
  logic [LEN_W-1:0] len_q, cnt_q, last_idx;
  logic [7:0]       id_q, tx_pid, rx_store, cks;
  logic             par_err, is_pub, is_sub, in_resp, beat, is_last;

  lin_pid_unit u_pid (
    .id_i      (id_q),
    .rx_byte_i (rx_data_i),
    .par_off_i (par_off_q),
    .tx_byte_o (tx_pid),
    .rx_store_o(rx_store),
    .par_err_o (par_err)
  );

  lin_len_sel #(.LEN_W(LEN_W)) u_len (
    .id_mode_i (len_mode_q),
    .len_i     (len_q),
    .id_bits_i (id_q[5:4]),
    .last_idx_o(last_idx)
  );

  lin_cksum_acc #(.DW(8)) u_cks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == ST_IDLE && start_i),
    .add_i (state_q == ST_DATA && beat),
    .byte_i(is_pub ? pub_data_i : rx_data_i),
    .cks_o (cks)
  );

  assign is_pub  = act_q == ACT_PUBLISH;
  assign is_sub  = act_q == ACT_SUBSCRIBE;
  assign in_resp = state_q == ST_DATA || state_q == ST_CKS;
  assign is_last = cnt_q == last_idx;

  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = 8'h00;
    unique case (state_q)
      ST_HDR_TX: begin tx_valid_o = 1'b1;               tx_data_o = tx_pid;     end
      ST_DATA:   begin tx_valid_o = is_pub && pub_valid_i; tx_data_o = pub_data_i; end
      ST_CKS:    begin tx_valid_o = is_pub;             tx_data_o = cks;        end
      default: ;
    endcase
    rx_ready_o  = state_q == ST_HDR_RX || (in_resp && !is_pub);
    pub_ready_o = state_q == ST_DATA && is_pub && tx_ready_i;
    beat        = is_pub ? (tx_valid_o && tx_ready_i) : (rx_valid_i && rx_ready_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      act_q       <= ACT_IGNORE;
      hdr_tx_q    <= 1'b0;
      par_off_q   <= 1'b0;
      len_mode_q  <= 1'b0;
      len_q       <= '0;
      cnt_q       <= '0;
      id_q        <= '0;
      pid_err_o   <= 1'b0;
      cks_err_o   <= 1'b0;
      done_o      <= 1'b0;
      sub_valid_o <= 1'b0;
      sub_data_o  <= '0;
    end else begin
      done_o      <= 1'b0;
      sub_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          act_q      <= node_act_e'(cfg_act_i);
          hdr_tx_q   <= hdr_tx_i;
          par_off_q  <= cfg_par_off_i;
          len_mode_q <= cfg_len_mode_i;
          len_q      <= cfg_len_i;
          id_q       <= cfg_id_i;
          cnt_q      <= '0;
          pid_err_o  <= 1'b0;
          cks_err_o  <= 1'b0;
          state_q    <= hdr_tx_i ? ST_HDR_TX : ST_HDR_RX;
        end
        ST_HDR_TX: if (tx_ready_i) state_q <= ST_DATA;
        ST_HDR_RX: if (rx_valid_i) begin
          id_q      <= rx_store;
          pid_err_o <= par_err;
          state_q   <= ST_DATA;
        end
        ST_DATA: if (beat) begin
          if (is_sub) begin
            sub_valid_o <= 1'b1;
            sub_data_o  <= rx_data_i;
          end
          if (is_last) begin
            cnt_q   <= '0;
            state_q <= ST_CKS;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CKS: if (beat) begin
          if (is_sub && rx_data_i != cks) cks_err_o <= 1'b1;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign pid_o  = hdr_tx_q ? tx_pid : id_q;

  // R11
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R4
  pid_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HDR_RX && rx_valid_i && !par_off_q |=> pid_o[7:6] == 2'b00);

  // R9
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !is_pub && !is_sub |=> !sub_valid_o && !cks_err_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> cnt_q <= last_idx);

  // R8
  sub_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sub_valid_o) |-> is_sub);

  dir_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_valid_o && rx_ready_o));
endmodule

// File: tb/lin_resp_ctrl_test.sv
module lin_resp_ctrl_test;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       start_i = 0, hdr_tx_i = 0, cfg_par_off_i = 0, cfg_len_mode_i = 0;
  logic [1:0] cfg_act_i = 0;
  logic [7:0] cfg_len_i = 0, cfg_id_i = 0;
  logic [7:0] tx_data_o, rx_data_i = 0, pub_data_i = 0, sub_data_o, pid_o;
  logic       tx_valid_o, tx_ready_i = 0, rx_valid_i = 0, rx_ready_o;
  logic       pub_valid_i = 0, pub_ready_o, sub_valid_o;
  logic       pid_err_o, cks_err_o, done_o, busy_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] pay [256];

  always #2 clk_i = ~clk_i;

  lin_resp_ctrl uut (.*);

  typedef struct packed {
    logic       hdr_tx;
    logic       par_off;
    logic [1:0] act;
    logic       len_mode;
    logic [7:0] len;
    logic [7:0] id;
    logic       bad_par;
    logic       bad_cks;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd1, 1'b0, 8'd2,   8'h3C, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'd2, 1'b1, 8'd0,   8'h12, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'd2, 1'b1, 8'd0,   8'h25, 1'b0, 1'b1},
    '{1'b1, 1'b0, 2'd1, 1'b1, 8'd0,   8'h3F, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd0, 1'b0, 8'd0,   8'hC5, 1'b0, 1'b0},
    '{1'b1, 1'b1, 2'd1, 1'b0, 8'd4,   8'hA7, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'd2, 1'b1, 8'd0,   8'h0A, 1'b1, 1'b0},
    '{1'b0, 1'b0, 2'd0, 1'b0, 8'd5,   8'h21, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd3, 1'b1, 8'd0,   8'h31, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd2, 1'b0, 8'd255, 8'h07, 1'b0, 1'b0}
  };

  function automatic logic [7:0] f_pid(input logic [7:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id[5:0]};
  endfunction

  function automatic int f_nbytes(input logic mode, input logic [7:0] len, input logic [7:0] id);
    if (!mode) return int'(len) + 1;
    case (id[5:4])
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] f_cks(input int n);
    logic [8:0] s = 0;
    for (int k = 0; k < n; k++) begin
      s = {1'b0, s[7:0]} + {1'b0, pay[k]};
      s = {1'b0, s[7:0] + {7'd0, s[8]}};
    end
    return ~s[7:0];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act_v, input logic [15:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic get_tx(output logic [7:0] b, input int stall);
    logic [7:0] first;
    @(negedge clk_i);
    while (!tx_valid_o) @(negedge clk_i);
    first = tx_data_o;
    if (stall > 0) begin
      repeat (stall) @(negedge clk_i);
      chk(tx_valid_o && tx_data_o == first, "R11 hold under stall", {7'd0, tx_valid_o, tx_data_o}, {8'h01, first});
    end
    b = tx_data_o;
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    tx_ready_i = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    while (!rx_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic run_frame(input vec_t v, input int tag);
    logic [7:0] b, raw, exp_b;
    int n;
    bit ok, seen;
    string lreq;
    n    = f_nbytes(v.len_mode, v.len, v.id);
    lreq = v.len_mode ? "R6 length" : "R5 length";
    for (int k = 0; k < n; k++) pay[k] = 8'(tag * 37 + k * 53 + 8'hC1);
    @(negedge clk_i);
    hdr_tx_i = v.hdr_tx; cfg_par_off_i = v.par_off; cfg_act_i = v.act;
    cfg_len_mode_i = v.len_mode; cfg_len_i = v.len; cfg_id_i = v.id;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (v.hdr_tx) begin
      get_tx(b, 0);
      exp_b = v.par_off ? v.id : f_pid(v.id);
      chk(b == exp_b, v.par_off ? "R3 tx header" : "R2 tx header", {8'd0, b}, {8'd0, exp_b});
    end else begin
      raw = v.par_off ? v.id : (f_pid(v.id) ^ (v.bad_par ? 8'h40 : 8'h00));
      send_rx(raw);
      exp_b = v.par_off ? raw : {2'b00, raw[5:0]};
      chk(pid_o == exp_b && pid_err_o == (v.bad_par && !v.par_off),
          v.par_off ? "R3 rx header" : "R4 rx header",
          {7'd0, pid_err_o, pid_o}, {7'd0, v.bad_par, exp_b});
    end
    ok = 1;
    if (v.act == 2'd1) begin
      pub_valid_i = 1'b1;
      for (int k = 0; k < n; k++) begin
        pub_data_i = pay[k];
        get_tx(b, (k == 0) ? 3 : 0);
        if (b != pay[k]) ok = 0;
      end
      pub_valid_i = 1'b0;
      chk(ok, "R7 data", 16'(ok), 16'd1);
      get_tx(b, 2);
      chk(b == f_cks(n), "R7 checksum", {8'd0, b}, {8'd0, f_cks(n)});
      chk(done_o, lreq, 16'(done_o), 16'd1);
    end else begin
      seen = 0;
      for (int k = 0; k < n; k++) begin
        send_rx(pay[k]);
        if (sub_valid_o) seen = 1;
        if (v.act == 2'd2 && !(sub_valid_o && sub_data_o == pay[k])) ok = 0;
        if (done_o) ok = 0;
      end
      if (v.act == 2'd2) chk(ok, "R8 capture", 16'(ok), 16'd1);
      else chk(!seen, "R9 no capture", 16'(seen), 16'd0);
      send_rx(f_cks(n) ^ (v.bad_cks ? 8'h01 : 8'h00));
      chk(done_o && ok, lreq, {done_o, 7'd0, 7'd0, ok}, 16'h8001);
      if (v.act == 2'd2) chk(cks_err_o == v.bad_cks, "R8 checksum flag", 16'(cks_err_o), 16'(v.bad_cks));
      else chk(!cks_err_o, "R9 no checksum flag", 16'(cks_err_o), 16'd0);
    end
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R10 single pulse", {done_o, busy_o}, 16'd0);
  endtask

  initial begin
    logic [7:0] b;
    bit ok;
    repeat (3) @(negedge clk_i);
    // R1
    chk(!busy_o && !done_o && !tx_valid_o && !rx_ready_o && !pub_ready_o &&
        !sub_valid_o && !pid_err_o && !cks_err_o, "R1 reset state",
        {busy_o, done_o, tx_valid_o, rx_ready_o, pub_ready_o, sub_valid_o, pid_err_o, cks_err_o}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !tx_valid_o && !rx_ready_o, "R1 idle after release",
        {busy_o, tx_valid_o, rx_ready_o}, 16'd0);

    for (int i = 0; i < NV; i++) run_frame(VECS[i], i);

    // R12: configuration altered mid-frame
    for (int k = 0; k < 2; k++) pay[k] = 8'(8'hF0 + k * 9);
    @(negedge clk_i);
    hdr_tx_i = 1; cfg_par_off_i = 0; cfg_act_i = 2'd1; cfg_len_mode_i = 0;
    cfg_len_i = 8'd1; cfg_id_i = 8'h10;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    hdr_tx_i = 0; cfg_par_off_i = 1; cfg_act_i = 2'd2; cfg_len_i = 8'd9; cfg_id_i = 8'hFF;
    get_tx(b, 0);
    chk(b == f_pid(8'h10), "R12 header unaffected", {8'd0, b}, {8'd0, f_pid(8'h10)});
    ok = 1;
    pub_valid_i = 1'b1;
    for (int k = 0; k < 2; k++) begin
      pub_data_i = pay[k];
      get_tx(b, 0);
      if (b != pay[k]) ok = 0;
    end
    pub_valid_i = 1'b0;
    get_tx(b, 0);
    chk(ok && b == f_cks(2) && done_o, "R12 length and action kept",
        {7'd0, done_o, b}, {8'h01, f_cks(2)});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule